// File: doc/BRIEF.md
# Synchronous programming-link serial engine

This block is the host end of a two-wire synchronous link used to put a target device into programming mode and exchange bytes with it. The host drives a link clock, which a programmable tick divider derives from the system clock. The host drives the data line while it transmits, and releases the line and samples it while it receives. Every transfer is a fixed 12-bit frame: a low start bit, eight data bits with the least significant bit first, an even-parity bit, then two high stop bits.

A pulse on `en_req_i` starts the link. The engine drives data high and holds the link clock low for a programmable guard time. It then starts the clock and sends two back-to-back BREAKs, which hold data low for 24 bit times, before it reports ready. A pulse on `dis_req_i` takes both lines to high impedance at once. The core side moves bytes over a valid/ready handshake. It asks for one received frame by pulsing `rx_req_i` and gets the byte back with parity and framing flags.

Top module: `plink_engine`

## Requirements
- R1: After reset both output enables are low, both line outputs are low, `tx_ready_o` is low and `rx_valid_o` is low.
- R2: The cycle after `en_req_i` is accepted, both enables are high, data is high and the link clock is low. The clock first goes high `guard_i + div_i` cycles after the enable request was accepted.
- R3: Once running, the link clock toggles exactly every `div_i` system cycles, with or without a frame in progress. `div_i` must be at least 2.
- R4: After the guard time, data is low at 24 consecutive rising link-clock edges (two BREAKs), then returns high. Only after that does `tx_ready_o` rise.
- R5: A transmitted frame carries bit 0 = 0, bits 8:1 = data (LSB first), bit 9 = XOR of the data bits and bits 11:10 = 1. The data line changes only when the link clock falls, so a target sampling on rising edges sees each bit.
- R6: `tx_ready_o` is high only when the link is up and no frame is in progress. A handshake starts exactly one frame and drops ready on the next cycle. When `tx_valid_i` and `rx_req_i` arrive together, the transmit wins.
- R7: An accepted receive request drops the data output enable from the next cycle until the frame completes. The engine samples on rising link-clock edges. While the line stays high it waits for the start bit without counting.
- R8: On completion `rx_valid_o` pulses for one cycle with `rx_data_o` = frame bits 8:1. `rx_par_err_o` is set when data plus parity hold an odd number of ones. `rx_frm_err_o` is set when either stop bit is low.
- R9: The cycle after `dis_req_i`, both enables and both line outputs are low and `tx_ready_o` is low. Any frame in flight is dropped and produces no `rx_valid_o`.
- R10: While the link is down, `tx_valid_i` and `rx_req_i` have no effect: enables stay low and `tx_ready_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | System cycles per link-clock half period (at least 2) |
| guard_i | input | GRD_W | Guard cycles with data high before the link clock starts |
| en_req_i | input | 1 | Start link: guard, BREAKs, then ready |
| dis_req_i | input | 1 | Stop link and tri-state both lines |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_data_i | input | 8 | Transmit byte |
| tx_ready_o | output | 1 | Link up and idle; accepts a byte or receive request |
| rx_req_i | input | 1 | Request reception of one frame |
| rx_valid_o | output | 1 | One-cycle pulse with a received byte |
| rx_data_o | output | 8 | Received byte |
| rx_par_err_o | output | 1 | Received parity mismatch |
| rx_frm_err_o | output | 1 | Received stop bit low |
| link_clk_o | output | 1 | Link clock value |
| link_clk_oe_o | output | 1 | Link clock driver enable |
| link_dat_o | output | 1 | Data line value |
| link_dat_oe_o | output | 1 | Data line driver enable |
| link_dat_i | input | 1 | Data line as seen at the pad |

## Verification
Link outputs respond one system cycle after a request strobe, and the bench samples them at the falling system-clock edge right after that. The first link-clock rise is due `guard_i + div_i` cycles after enable, and the bench counts those cycles exactly. A bench-side target emulator follows the link clock instead of fixed delays. It reads frame bits at each rising link edge and changes the input line at each falling one, so every bit is judged half a link period after it settles. A received byte is due on the cycle after the rising edge that samples its second stop bit, and the monitor pops the scoreboard whenever `rx_valid_o` is seen.

// File: rtl/plink_pkg.sv
package plink_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = DATA_W + 4;
  localparam int unsigned BRK_FRAMES = 2;
  localparam int unsigned CNT_W      = $clog2(BRK_FRAMES * FRAME_BITS + 1);

  typedef enum logic [1:0] {ST_OFF, ST_GUARD, ST_BREAK, ST_LINK} link_st_e;

  // stop,stop,parity,data,start ; shifted out from bit 0
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {2'b11, ^d, d, 1'b0};
  endfunction
endpackage

// File: rtl/plink_tick.sv
module plink_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q >= div_i - DIV_W'(1));
  assign tick_o = run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || wrap)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/plink_seq.sv
module plink_seq
  import plink_pkg::*;
#(
  parameter int unsigned GRD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic [GRD_W-1:0] guard_i,
  input  logic             brk_end_i,
  output link_st_e         st_o,
  output logic             brk_load_o
);
  link_st_e         st_q;
  logic [GRD_W-1:0] gcnt_q;
  logic             gdone;

  assign gdone      = ({1'b0, gcnt_q} + (GRD_W+1)'(1)) >= {1'b0, guard_i};
  assign brk_load_o = (st_q == ST_GUARD) && gdone && !dis_req_i;
  assign st_o       = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      gcnt_q <= '0;
    end else if (dis_req_i) begin
      st_q   <= ST_OFF;
      gcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          gcnt_q <= '0;
          if (en_req_i) st_q <= ST_GUARD;
        end
        ST_GUARD: begin
          gcnt_q <= gcnt_q + GRD_W'(1);
          if (gdone) st_q <= ST_BREAK;
        end
        ST_BREAK: if (brk_end_i) st_q <= ST_LINK;
        default:  st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/plink_shift.sv
module plink_shift
  import plink_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  link_st_e              st_i,
  input  logic                  tick_i,
  input  logic                  brk_load_i,
  input  logic                  tx_load_i,
  input  logic [FRAME_BITS-1:0] tx_frame_i,
  input  logic                  rx_load_i,
  input  logic                  dat_i,
  output logic                  link_clk_o,
  output logic                  link_dat_o,
  output logic                  dat_oe_o,
  output logic                  idle_o,
  output logic                  brk_end_o,
  output logic                  rx_done_o,
  output logic [FRAME_BITS-1:0] rx_frame_o
);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_BRK   = CNT_W'(BRK_FRAMES * FRAME_BITS);

  logic                  clk_q, dat_q, rx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  fall, rise, on, start_wait;

  assign on         = (st_i != ST_OFF);
  assign fall       = tick_i & clk_q;
  assign rise       = tick_i & ~clk_q;
  assign idle_o     = (cnt_q == '0);
  assign start_wait = rx_q && (cnt_q == CNT_FRAME) && dat_i;
  assign rx_frame_o = {dat_i, sh_q[FRAME_BITS-1:1]};
  assign rx_done_o  = rise && rx_q && (cnt_q == CNT_W'(1));
  assign brk_end_o  = (st_i == ST_BREAK) && fall && idle_o;

  assign link_clk_o = on & clk_q;
  assign link_dat_o = on & (dat_q | (st_i == ST_GUARD));
  assign dat_oe_o   = on & ~rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= 1'b0; dat_q <= 1'b0; rx_q <= 1'b0;
      sh_q  <= '0;   cnt_q <= '0;
    end else if (st_i == ST_OFF) begin
      clk_q <= 1'b0; dat_q <= 1'b0; rx_q <= 1'b0;
      sh_q  <= '0;   cnt_q <= '0;
    end else if (st_i == ST_GUARD) begin
      clk_q <= 1'b0;
      dat_q <= 1'b1;
      rx_q  <= 1'b0;
      if (brk_load_i) begin
        sh_q  <= '0;
        cnt_q <= CNT_BRK;
      end
    end else begin
      if (tick_i) clk_q <= ~clk_q;
      if (tx_load_i) begin
        sh_q  <= tx_frame_i;
        cnt_q <= CNT_FRAME;
        rx_q  <= 1'b0;
      end else if (rx_load_i) begin
        sh_q  <= '0;
        cnt_q <= CNT_FRAME;
        rx_q  <= 1'b1;
      end else if (!idle_o) begin
        if (!rx_q && fall) begin
          dat_q <= sh_q[0];
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (rx_q && rise && !start_wait) begin
          sh_q  <= rx_frame_o;
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            rx_q  <= 1'b0;
            dat_q <= 1'b1;
          end
        end
      end else if (brk_end_o) begin
        dat_q <= 1'b1;  // idle high after the last BREAK bit time
      end
    end
  end
endmodule

// File: rtl/plink_rx_chk.sv
module plink_rx_chk
  import plink_pkg::*;
(
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic [DATA_W-1:0]     data_o,
  output logic                  par_err_o,
  output logic                  frm_err_o
);
  assign data_o    = frame_i[DATA_W:1];
  assign par_err_o = ^frame_i[DATA_W+1:1];
  assign frm_err_o = frame_i[0] | ~frame_i[DATA_W+2] | ~frame_i[DATA_W+3];
endmodule

// File: rtl/plink_engine.sv
module plink_engine
  import plink_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned GRD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [GRD_W-1:0]  guard_i,
  input  logic              en_req_i,
  input  logic              dis_req_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              rx_req_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_par_err_o,
  output logic              rx_frm_err_o,
  output logic              link_clk_o,
  output logic              link_clk_oe_o,
  output logic              link_dat_o,
  output logic              link_dat_oe_o,
  input  logic              link_dat_i
);
  link_st_e              st;
  logic                  tick, brk_load, brk_end, idle, rx_done;
  logic                  tx_load, rx_load;
  logic [FRAME_BITS-1:0] rx_frame;
  logic [DATA_W-1:0]     dec_data;
  logic                  dec_perr, dec_ferr;

  assign tx_ready_o    = (st == ST_LINK) && idle;
  assign tx_load       = tx_valid_i && tx_ready_o;
  assign rx_load       = rx_req_i && tx_ready_o && !tx_valid_i;
  assign link_clk_oe_o = (st != ST_OFF);

  plink_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni,
    .run_i  ((st == ST_BREAK) || (st == ST_LINK)),
    .div_i,
    .tick_o (tick)
  );

  plink_seq #(.GRD_W(GRD_W)) u_seq (
    .clk_i, .rst_ni, .en_req_i, .dis_req_i, .guard_i,
    .brk_end_i  (brk_end),
    .st_o       (st),
    .brk_load_o (brk_load)
  );

  plink_shift u_shift (
    .clk_i, .rst_ni,
    .st_i       (st),
    .tick_i     (tick),
    .brk_load_i (brk_load),
    .tx_load_i  (tx_load),
    .tx_frame_i (build_frame(tx_data_i)),
    .rx_load_i  (rx_load),
    .dat_i      (link_dat_i),
    .link_clk_o (link_clk_o),
    .link_dat_o (link_dat_o),
    .dat_oe_o   (link_dat_oe_o),
    .idle_o     (idle),
    .brk_end_o  (brk_end),
    .rx_done_o  (rx_done),
    .rx_frame_o (rx_frame)
  );

  plink_rx_chk u_rx_chk (
    .frame_i   (rx_frame),
    .data_o    (dec_data),
    .par_err_o (dec_perr),
    .frm_err_o (dec_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o   <= 1'b0;
      rx_data_o    <= '0;
      rx_par_err_o <= 1'b0;
      rx_frm_err_o <= 1'b0;
    end else begin
      rx_valid_o <= rx_done && !dis_req_i;
      if (rx_done) begin
        rx_data_o    <= dec_data;
        rx_par_err_o <= dec_perr;
        rx_frm_err_o <= dec_ferr;
      end
    end
  end
endmodule

// File: rtl/plink_engine_chk.sv
module plink_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dis_req_i,
  input logic tx_valid_i,
  input logic rx_req_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic link_clk_o,
  input logic link_clk_oe_o,
  input logic link_dat_o,
  input logic link_dat_oe_o
);
  p_dis_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dis_req_i) |-> !link_dat_oe_o && !link_clk_oe_o);

  p_off_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_clk_oe_o |-> !link_clk_o && !link_dat_o && !tx_ready_o && !link_dat_oe_o);

  p_start_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_clk_oe_o) |-> link_dat_o && !link_clk_o && link_dat_oe_o);

  p_ready_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> link_dat_oe_o && link_dat_o);

  p_accept_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o |=> !tx_ready_o);

  p_rx_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_i && tx_ready_o && !tx_valid_i && !dis_req_i |=> !link_dat_oe_o);

  p_rx_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_data_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_dat_oe_o && $past(link_dat_oe_o) && link_clk_oe_o && $past(link_clk_oe_o)
    && !$stable(link_dat_o) |-> $fell(link_clk_o));
endmodule

bind plink_engine plink_engine_chk u_chk (
  .clk_i, .rst_ni, .dis_req_i, .tx_valid_i, .rx_req_i, .tx_ready_o, .rx_valid_o,
  .link_clk_o, .link_clk_oe_o, .link_dat_o, .link_dat_oe_o
);

// File: tb/plink_engine_bench.sv
module plink_engine_bench;
  localparam int DIV = 4;
  localparam int GRD = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [15:0] div_i = 16'(DIV);
  logic [7:0] guard_i = 8'(GRD);
  logic       en_req_i = 0, dis_req_i = 0, tx_valid_i = 0, rx_req_i = 0;
  logic [7:0] tx_data_i = '0;
  logic       tx_ready_o, rx_valid_o, rx_par_err_o, rx_frm_err_o;
  logic [7:0] rx_data_o;
  logic       link_clk_o, link_clk_oe_o, link_dat_o, link_dat_oe_o;
  logic       link_dat_i = 1'b1;

  always #2 clk = ~clk;

  plink_engine u_plink_engine (
    .clk_i(clk), .rst_ni, .div_i, .guard_i, .en_req_i, .dis_req_i,
    .tx_valid_i, .tx_data_i, .tx_ready_o, .rx_req_i, .rx_valid_o,
    .rx_data_o, .rx_par_err_o, .rx_frm_err_o, .link_clk_o, .link_clk_oe_o,
    .link_dat_o, .link_dat_oe_o, .link_dat_i
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d);
    return {2'b11, ^d, d, 1'b0};
  endfunction

  logic [7:0]  tx_q[$];
  logic [9:0]  rx_q[$];   // {perr, ferr, data}
  event        ev_fall;
  bit          brk_phase = 0;
  int          brk_low = 0, tog_cnt = 0, bad_iv = 0, since_tog = 0, rxv_cnt = 0;
  bit          have_tog = 0, prev_clk = 0, in_frm = 0;
  int          nb = 0;
  logic [11:0] bits;

  // monitor / target emulator
  always @(negedge clk) begin
    since_tog++;
    if (!link_clk_oe_o) begin
      have_tog = 0; in_frm = 0; prev_clk = 0;
    end else if (link_clk_o != prev_clk) begin
      if (have_tog && since_tog != DIV) bad_iv++;
      have_tog = 1; tog_cnt++; since_tog = 0;
      if (link_clk_o && link_dat_oe_o) begin
        if (brk_phase) begin
          if (!link_dat_o) brk_low++;
        end else if (!in_frm) begin
          if (!link_dat_o) begin in_frm = 1; bits = '0; nb = 1; end
        end else begin
          bits[nb] = link_dat_o; nb++;
          if (nb == 12) begin
            in_frm = 0;
            if (tx_q.size() == 0) chk(0, "R5", "unexpected frame", int'(bits), 0);
            else begin
              logic [7:0] e;
              e = tx_q.pop_front();
              chk(bits == exp_frame(e), "R5", "tx frame", int'(bits), int'(exp_frame(e)));
            end
          end
        end
      end
      if (!link_clk_o) -> ev_fall;
      prev_clk = link_clk_o;
    end
    if (rx_valid_o) begin
      rxv_cnt++;
      if (rx_q.size() == 0) chk(0, "R8", "unexpected rx_valid", int'(rx_data_o), 0);
      else begin
        logic [9:0] e;
        e = rx_q.pop_front();
        chk({rx_par_err_o, rx_frm_err_o, rx_data_o} == e, "R8", "rx byte/flags",
            int'({rx_par_err_o, rx_frm_err_o, rx_data_o}), int'(e));
      end
    end
  end

  task automatic wait_ready();
    while (!tx_ready_o) @(negedge clk);
  endtask

  task automatic drv_tx(input logic [7:0] d, input bit push);
    wait_ready();
    if (push) tx_q.push_back(d);
    tx_valid_i = 1; tx_data_i = d;
    @(negedge clk);
    tx_valid_i = 0;
    chk(!tx_ready_o, "R6", "ready after accept", int'(tx_ready_o), 0);
  endtask

  task automatic drv_rx(input logic [7:0] d, input bit perr, input bit ferr);
    logic [11:0] f;
    int oe_bad = 0;
    f = {1'b1, ~ferr, (^d) ^ perr, d, 1'b0};
    wait_ready();
    rx_q.push_back({perr, ferr, d});
    rx_req_i = 1;
    @(negedge clk);
    rx_req_i = 0;
    fork
      begin
        repeat (2) @(ev_fall);  // line held high: engine must keep waiting
        for (int i = 0; i < 12; i++) begin @(ev_fall); link_dat_i = f[i]; end
        @(ev_fall); link_dat_i = 1'b1;
      end
      begin
        do begin
          if (link_dat_oe_o) oe_bad++;
          @(negedge clk);
        end while (!rx_valid_o);
      end
    join
    chk(oe_bad == 0, "R7", "data released during rx", oe_bad, 0);
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < 300 && tx_q.size() != 0; i++) @(negedge clk);
    chk(tx_q.size() == 0, req, "tx frames outstanding", tx_q.size(), 0);
  endtask

  initial begin
    int n, any, rv0;
    repeat (3) @(negedge clk);
    chk({link_clk_oe_o, link_dat_oe_o, link_clk_o, link_dat_o, tx_ready_o, rx_valid_o} == 0,
        "R1", "reset outputs",
        int'({link_clk_oe_o, link_dat_oe_o, link_clk_o, link_dat_o, tx_ready_o, rx_valid_o}), 0);
    rst_ni = 1;
    @(negedge clk);

    // R10: requests while down
    any = 0;
    tx_valid_i = 1; rx_req_i = 1;
    repeat (6) begin
      @(negedge clk);
      if (link_clk_oe_o || link_dat_oe_o || tx_ready_o) any++;
    end
    tx_valid_i = 0; rx_req_i = 0;
    chk(any == 0, "R10", "activity while down", any, 0);

    // R2 / R4: enable
    brk_phase = 1;
    en_req_i = 1;
    @(negedge clk);
    en_req_i = 0;
    chk({link_clk_oe_o, link_dat_oe_o, link_dat_o, link_clk_o} == 4'b1110, "R2",
        "enable outputs", int'({link_clk_oe_o, link_dat_oe_o, link_dat_o, link_clk_o}), 4'he);
    n = 0;
    while (!link_clk_o && n < 100) begin @(negedge clk); n++; end
    chk(n == GRD + DIV, "R2", "cycles to first clock rise", n, GRD + DIV);
    wait_ready();
    brk_phase = 0;
    chk(brk_low == 24, "R4", "break low bit times", brk_low, 24);
    chk(link_dat_o == 1'b1, "R4", "line high after break", int'(link_dat_o), 1);

    // R3: idle clock
    n = tog_cnt;
    repeat (10 * DIV) @(negedge clk);
    chk(tog_cnt - n == 10, "R3", "idle toggles", tog_cnt - n, 10);

    // R5: frames
    drv_tx(8'h00, 1); drv_tx(8'hFF, 1); drv_tx(8'hA5, 1);
    drv_tx(8'h3C, 1); drv_tx(8'h80, 1);
    flush("R5");

    // R6: transmit wins over simultaneous receive request
    rv0 = rxv_cnt;
    wait_ready();
    tx_q.push_back(8'h96);
    tx_valid_i = 1; tx_data_i = 8'h96; rx_req_i = 1;
    @(negedge clk);
    tx_valid_i = 0; rx_req_i = 0;
    chk(link_dat_oe_o == 1'b1, "R6", "tx kept data driven", int'(link_dat_oe_o), 1);
    flush("R6");
    repeat (4 * DIV) @(negedge clk);
    chk(rxv_cnt == rv0, "R6", "no rx on collision", rxv_cnt - rv0, 0);

    // R7 / R8: receive
    drv_rx(8'h5A, 0, 0);
    drv_rx(8'h01, 1, 0);
    drv_rx(8'hC3, 0, 1);
    drv_rx(8'hFF, 1, 1);
    chk(rx_q.size() == 0, "R8", "rx outstanding", rx_q.size(), 0);
    chk(bad_iv == 0 && tog_cnt > 100, "R3", "toggle interval errors", bad_iv, 0);

    // R9: disable mid frame
    drv_tx(8'h55, 0);
    repeat (30) @(negedge clk);
    dis_req_i = 1;
    @(negedge clk);
    dis_req_i = 0;
    chk({link_clk_oe_o, link_dat_oe_o, link_clk_o, link_dat_o, tx_ready_o} == 0, "R9",
        "outputs after disable",
        int'({link_clk_oe_o, link_dat_oe_o, link_clk_o, link_dat_o, tx_ready_o}), 0);
    rv0 = rxv_cnt; any = 0;
    repeat (200) begin
      @(negedge clk);
      if (link_clk_oe_o || link_dat_oe_o) any++;
    end
    chk(any == 0 && rxv_cnt == rv0, "R9", "activity after disable", any + rxv_cnt - rv0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule